// File: doc/BRIEF.md
# UART DMA Ready Flag Generator

This block produces the two DMA request flags of a UART: a receive flag that asks a DMA controller to drain the receive FIFO, and a transmit flag that reports on the transmit FIFO. Both flags are registered and can be read by software or wired straight to a DMA controller. The block takes the FIFO occupancy counts, a receive trigger-level indication, a receive character time-out indication and two control bits. It drives the flags in one of two signalling schemes. The FIFOs and the DMA controller are outside the block.

In single-transfer signalling the flags track occupancy directly. The receive flag is low whenever a character is waiting. The transmit flag is high whenever the transmitter holds at least one character. In burst signalling the flags have hysteresis. The receive flag falls when the trigger level or a time-out is reported, and stays low until the receive FIFO is completely empty. The transmit flag rises when the transmit FIFO is full, and stays high until it has completely emptied.

When the FIFO is disabled, the holding register is presented to the block as a count of zero or one.

Top module: `uart_dma_ready`

## Requirements
- R1: While `rst_n` is low, both `rx_dreq_n` and `tx_dreq_n` are 1.
- R2: Burst signalling applies only when `dma_sel` = 1 and `fifo_en` = 1. Any other combination, including `dma_sel` = 1 with `fifo_en` = 0, uses single-transfer signalling.
- R3: In single-transfer signalling, `rx_dreq_n` becomes 0 one clock after `rx_count` is non-zero and 1 one clock after `rx_count` is zero, whatever `fifo_en` is.
- R4: In single-transfer signalling, `tx_dreq_n` becomes 0 one clock after `tx_count` is zero and 1 one clock after `tx_count` is non-zero.
- R5: In burst signalling with `rx_count` non-zero, `rx_dreq_n` becomes 0 one clock after `rx_trig_hit` = 1 or `rx_timeout` = 1.
- R6: In burst signalling, `rx_dreq_n` becomes 1 one clock after `rx_count` is zero. With `rx_count` non-zero and neither indication set, `rx_dreq_n` keeps its value.
- R7: In burst signalling, `tx_dreq_n` becomes 1 one clock after `tx_count` equals DEPTH (16 by default).
- R8: In burst signalling, `tx_dreq_n` becomes 0 one clock after `tx_count` is zero. With `tx_count` strictly between zero and DEPTH, `tx_dreq_n` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO mode enable |
| dma_sel | input | 1 | DMA signalling select: 0 selects single-transfer, 1 selects burst (needs `fifo_en`) |
| rx_count | input | CW | Characters in the receive FIFO or holding register |
| rx_trig_hit | input | 1 | Receive trigger level reached |
| rx_timeout | input | 1 | Receive character time-out |
| tx_count | input | CW | Characters in the transmit FIFO or holding register |
| rx_dreq_n | output | 1 | Receive DMA request, active low |
| tx_dreq_n | output | 1 | Transmit DMA flag |

## Verification
The hardest states to reach from the ports are the hold states of burst signalling. In these states the next flag value depends on history rather than on the present inputs. To reach them, the stimulus first drives the receive flag low with a trigger or a time-out, and then walks `rx_count` down through intermediate values with both indications clear. It also fills the transmit count to exactly DEPTH and drains it step by step, and approaches each hold state from both flag values. A separate pass sets `dma_sel` without `fifo_en` to show that burst behaviour stays off.

// File: rtl/uart_dma_ready_pkg.sv
package uart_dma_ready_pkg;

  typedef enum logic {
    SIG_SINGLE = 1'b0,
    SIG_BURST  = 1'b1
  } sig_mode_e;

endpackage

// File: rtl/uart_dma_mode_dec.sv
module uart_dma_mode_dec
  import uart_dma_ready_pkg::*;
(
  input  logic      fifo_en,
  input  logic      dma_sel,
  output sig_mode_e mode
);

  always_comb begin
    if (dma_sel && fifo_en) mode = SIG_BURST;
    else                    mode = SIG_SINGLE;
  end

endmodule

// File: rtl/uart_dma_rx_flag.sv
module uart_dma_rx_flag
  import uart_dma_ready_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sig_mode_e     mode,
  input  logic [CW-1:0] count,
  input  logic          trig_hit,
  input  logic          timeout,
  output logic          req_n
);

  logic req_q;
  logic req_d;
  logic empty;

  assign empty = (count == '0);

  // next-state
  always_comb begin
    req_d = req_q;
    if (mode == SIG_SINGLE) begin
      req_d = empty;
    end else if (empty) begin
      req_d = 1'b1;
    end else if (trig_hit || timeout) begin
      req_d = 1'b0;
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b1;
    else        req_q <= req_d;
  end

  assign req_n = req_q;

endmodule

// File: rtl/uart_dma_tx_flag.sv
module uart_dma_tx_flag
  import uart_dma_ready_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sig_mode_e     mode,
  input  logic [CW-1:0] count,
  output logic          flag
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic flag_q;
  logic flag_d;
  logic empty;
  logic full;

  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);

  // next-state
  always_comb begin
    flag_d = flag_q;
    if (mode == SIG_SINGLE) begin
      flag_d = !empty;
    end else if (empty) begin
      flag_d = 1'b0;
    end else if (full) begin
      flag_d = 1'b1;
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b1;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

endmodule

// File: rtl/uart_dma_ready.sv
module uart_dma_ready
  import uart_dma_ready_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          dma_sel,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_trig_hit,
  input  logic          rx_timeout,
  input  logic [CW-1:0] tx_count,
  output logic          rx_dreq_n,
  output logic          tx_dreq_n
);

  sig_mode_e mode;

  uart_dma_mode_dec u_dec (
    .fifo_en (fifo_en),
    .dma_sel (dma_sel),
    .mode    (mode)
  );

  uart_dma_rx_flag #(.CW(CW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .count    (rx_count),
    .trig_hit (rx_trig_hit),
    .timeout  (rx_timeout),
    .req_n    (rx_dreq_n)
  );

  uart_dma_tx_flag #(.DEPTH(DEPTH), .CW(CW)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .count (tx_count),
    .flag  (tx_dreq_n)
  );

endmodule

// File: rtl/uart_dma_ready_chk.sv
module uart_dma_ready_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          dma_sel,
  input logic [CW-1:0] rx_count,
  input logic          rx_trig_hit,
  input logic          rx_timeout,
  input logic [CW-1:0] tx_count,
  input logic          rx_dreq_n,
  input logic          tx_dreq_n
);

  logic burst;
  assign burst = dma_sel && fifo_en;

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_high_r1: assert (rx_dreq_n && tx_dreq_n)
        else $error("reset flags not high");
    end
  end

  // R2 and R3: single-transfer receive rule
  p_single_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !burst |=> (rx_dreq_n == ($past(rx_count) == '0)));

  // R2 and R4: single-transfer transmit rule
  p_single_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !burst |=> (tx_dreq_n == ($past(tx_count) != '0)));

  p_burst_rx_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && rx_count != '0 && (rx_trig_hit || rx_timeout)) |=> !rx_dreq_n);

  p_burst_rx_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && rx_count == '0) |=> rx_dreq_n);

  p_burst_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && rx_count != '0 && !rx_trig_hit && !rx_timeout) |=> $stable(rx_dreq_n));

  p_burst_tx_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && tx_count == CW'(DEPTH)) |=> tx_dreq_n);

  p_burst_tx_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && tx_count == '0) |=> !tx_dreq_n);

  p_burst_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && tx_count != '0 && tx_count != CW'(DEPTH)) |=> $stable(tx_dreq_n));

endmodule

bind uart_dma_ready uart_dma_ready_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fifo_en     (fifo_en),
  .dma_sel     (dma_sel),
  .rx_count    (rx_count),
  .rx_trig_hit (rx_trig_hit),
  .rx_timeout  (rx_timeout),
  .tx_count    (tx_count),
  .rx_dreq_n   (rx_dreq_n),
  .tx_dreq_n   (tx_dreq_n)
);

// File: tb/sim_uart_dma_ready.sv
`timescale 1ns/1ps
module sim_uart_dma_ready;

  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk;
  logic          rst_n;
  logic          fifo_en;
  logic          dma_sel;
  logic [CW-1:0] rx_count;
  logic          rx_trig_hit;
  logic          rx_timeout;
  logic [CW-1:0] tx_count;
  logic          rx_dreq_n;
  logic          tx_dreq_n;

  int n_tests;
  int n_fail;
  bit done;

  typedef struct {
    logic  rx;
    logic  tx;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  logic m_rx;
  logic m_tx;

  uart_dma_ready #(.DEPTH(DEPTH)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en     (fifo_en),
    .dma_sel     (dma_sel),
    .rx_count    (rx_count),
    .rx_trig_hit (rx_trig_hit),
    .rx_timeout  (rx_timeout),
    .tx_count    (tx_count),
    .rx_dreq_n   (rx_dreq_n),
    .tx_dreq_n   (tx_dreq_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // driver: apply one input set at a falling edge, predict next flags
  task automatic step(input logic fen, input logic dsel, input int rc,
                      input logic trig, input logic to, input int tc,
                      input string tag);
    exp_t e;
    logic burst;
    @(negedge clk);
    fifo_en     = fen;
    dma_sel     = dsel;
    rx_count    = CW'(rc);
    rx_trig_hit = trig;
    rx_timeout  = to;
    tx_count    = CW'(tc);
    burst = dsel && fen;
    if (!burst) begin
      m_rx = (rc == 0);
      m_tx = (tc != 0);
    end else begin
      if (rc == 0)          m_rx = 1'b1;
      else if (trig || to)  m_rx = 1'b0;
      if (tc == 0)          m_tx = 1'b0;
      else if (tc == DEPTH) m_tx = 1'b1;
    end
    e.rx = m_rx;
    e.tx = m_tx;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare just after the edge that registers the inputs
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_tests++;
      if (rx_dreq_n !== e.rx || tx_dreq_n !== e.tx) begin
        n_fail++;
        $display("FAIL %s: rx=%b tx=%b expected rx=%b tx=%b",
                 e.tag, rx_dreq_n, tx_dreq_n, e.rx, e.tx);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests = 0; n_fail = 0; done = 0;
    rst_n = 1'b1;
    fifo_en = 0; dma_sel = 0; rx_count = '0; tx_count = '0;
    rx_trig_hit = 0; rx_timeout = 0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    n_tests++;
    if (rx_dreq_n !== 1'b1 || tx_dreq_n !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: rx=%b tx=%b expected rx=1 tx=1", rx_dreq_n, tx_dreq_n);
    end
    m_rx = 1'b1; m_tx = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;

    // R3 R4: single-transfer, FIFO disabled (holding register 0/1)
    step(0, 0, 0, 0, 0, 0, "R4 empty tx low");
    step(0, 0, 1, 0, 0, 0, "R3 rx char present");
    step(0, 0, 1, 0, 0, 1, "R4 tx char loaded");
    step(0, 0, 0, 0, 0, 1, "R3 rx empty release");
    step(0, 0, 0, 0, 0, 0, "R4 tx empty again");
    // R3 R4: single-transfer with FIFO enabled
    step(1, 0, 4, 0, 0, 3, "R3 R4 fifo on single");
    step(1, 0, 4, 1, 0, 3, "R3 trig no effect in single");
    step(1, 0, 0, 0, 0, 0, "R3 R4 fifo on drained");

    // R2: select without FIFO enable stays single-transfer
    step(0, 1, 1, 0, 0, 1, "R2 dsel without fen rx");
    step(0, 1, 0, 0, 0, 1, "R2 dsel without fen release");
    step(0, 1, 0, 0, 0, 0, "R2 dsel without fen tx");

    // R5 R6: burst receive with hysteresis
    step(1, 1, 0, 0, 0, 0, "R6 burst empty");
    step(1, 1, 3, 0, 0, 0, "R6 below trigger stays high");
    step(1, 1, 8, 1, 0, 0, "R5 trigger asserts");
    step(1, 1, 5, 0, 0, 0, "R6 drain holds low");
    step(1, 1, 1, 0, 0, 0, "R6 last char holds low");
    step(1, 1, 0, 0, 0, 0, "R6 empty releases");
    step(1, 1, 2, 0, 1, 0, "R5 timeout asserts");
    step(1, 1, 2, 0, 0, 0, "R6 hold after timeout");
    step(1, 1, 0, 0, 0, 0, "R6 release after timeout");

    // R7 R8: burst transmit with hysteresis
    step(1, 1, 0, 0, 0, 5, "R8 partial fill stays low");
    step(1, 1, 0, 0, 0, 15, "R8 one short of full stays low");
    step(1, 1, 0, 0, 0, DEPTH, "R7 full raises");
    step(1, 1, 0, 0, 0, 10, "R8 drain holds high");
    step(1, 1, 0, 0, 0, 1, "R8 last char holds high");
    step(1, 1, 0, 0, 0, 0, "R8 empty lowers");

    // both directions together
    step(1, 1, 6, 0, 1, DEPTH, "R5 R7 combined");
    step(1, 1, 3, 0, 0, 4, "R6 R8 combined hold");
    step(1, 1, 0, 0, 0, 0, "R6 R8 combined release");

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule